// File: doc/BRIEF.md
# Video Input Sync Timing Validator

This block sits at the panel-side entry of a two-pixel-per-clock video port. It watches the incoming horizontal sync, vertical sync and display-enable on the port clock. It measures every horizontal segment in clocks and every vertical segment in lines, and compares each one against its own lower and upper limit. The two 18-bit pixel words (one for the first pixel and one for the second pixel of each clock) pass through unchanged while the timing is valid. They are forced to zero, which is black, while the validator is in its protection state.

The video stream has no back-pressure. Display-enable acts as the valid qualifier of the pixel words, there is no ready signal, and the block never stalls or buffers data. The pixel path is combinational from input to output. The sync inputs are registered once before any measurement takes place. Horizontal limits are in port clocks and vertical limits are in lines. A line begins at a rising edge of hsync, and a frame begins at a rising edge of vsync. Parameters hold the limits, and the defaults match a 1400x1050 panel fed at two pixels per clock.

Top module: `sync_timing_validator`

## Requirements
- R1: After reset, `timing_valid` is 0 and both pixel outputs are zero. This holds until a complete frame, bounded by two vsync rising edges, has been measured with no violation.
- R2: A line (from one hsync rising edge to the next) shorter than 762 or longer than 1023 clocks is a violation.
- R3: An hsync high time outside 8..250 clocks is a violation. On a line with display-enable, a gap outside 26..300 clocks from hsync falling to enable rising (the back porch) is also a violation.
- R4: On a line with display-enable, the enable must stay high for exactly 700 clocks, and the gap from enable falling to the next hsync rising must be at least 8 clocks. Any other case is a violation.
- R5: A frame shorter than 1058 or longer than 2046 lines is a violation. So is a frame that does not contain exactly 1050 enabled lines, or one whose enabled lines are not contiguous.
- R6: A vsync high time outside 1..62 lines, a vertical back porch (lines from vsync falling to the first enabled line) outside 6..125, or fewer than 1 line after the last enabled line are each a violation.
- R7: An inverted (active-low) vsync is reported as invalid timing.
- R8: While the protection state is active, both pixel outputs are zero for every input value.
- R9: A violation clears `timing_valid` no later than two clocks after the input edge that ends the offending segment.
- R10: `timing_valid` is set only at a frame boundary, and only when the frame that just ended had no violation.
- R11: The protection state is entered or left only at a frame boundary. It is entered at the end of any frame with a violation, and left at the end of a clean one. Pixels inside a frame therefore all pass or are all blanked.
- R12: Counters saturate. An hsync that stays absent for more than 1023 clocks is flagged before it returns, and the flag clears `timing_valid` within two clocks of the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| de_in | input | 1 | Display enable, qualifies the pixel words |
| pix_even_in | input | 18 | First pixel of the clock, 6 bits each of R,G,B |
| pix_odd_in | input | 18 | Second pixel of the clock |
| pix_even_out | output | 18 | First pixel, passed or forced to zero |
| pix_odd_out | output | 18 | Second pixel, passed or forced to zero |
| timing_valid | output | 1 | 1 while the measured timing is within limits |

## Verification
The embedded properties assume that sync and enable inputs are synchronous to the port clock. They also assume that enable never rises in the same clock as an hsync or vsync edge, so a segment always ends on a single event. The stimulus draws every segment length at random within its limits and drives all three controls on the falling clock edge. It changes vsync only on a clock where hsync also rises, as a source would normally do. Violations are injected one kind at a time into one line or into the vertical counts. An inverted-vsync burst deliberately breaks the frame framing, and no boundary checks are made until two true frames have passed.

// File: rtl/stv_pkg.sv
package stv_pkg;
  localparam int SIG_HS = 0;
  localparam int SIG_VS = 1;
  localparam int SIG_DE = 2;
  localparam int SIG_N  = 3;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } ctl_evt_t;
endpackage

// File: rtl/stv_edge.sv
module stv_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      prv_q <= '0;
    end else begin
      cur_q <= d;
      prv_q <= cur_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise[i] = cur_q[i] & ~prv_q[i];
    assign fall[i] = ~cur_q[i] & prv_q[i];
  end
endmodule

// File: rtl/stv_hmeas.sv
module stv_hmeas #(
  parameter int LINE_MIN_CLK = 762,
  parameter int LINE_MAX_CLK = 1023,
  parameter int HS_MIN_CLK   = 8,
  parameter int HS_MAX_CLK   = 250,
  parameter int HBP_MIN_CLK  = 26,
  parameter int HBP_MAX_CLK  = 300,
  parameter int HFP_MIN_CLK  = 8,
  parameter int ACT_CLK      = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise,
  input  logic hs_fall,
  input  logic de_rise,
  input  logic de_fall,
  output logic line_err
);
  localparam int CW = $clog2(LINE_MAX_CLK + 2);
  localparam logic [CW-1:0] CAP = CW'(LINE_MAX_CLK + 1);

  logic [CW-1:0] hc, t_fall, t_on, t_off;
  logic          seen, fell, de_on, de_done;
  logic [CW-1:0] bp_len, act_len, fp_len;
  logic          e_total, e_sync, e_bp, e_act, e_fp, e_ovl, e_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc      <= '0;
      seen    <= 1'b0;
      fell    <= 1'b0;
      de_on   <= 1'b0;
      de_done <= 1'b0;
      t_fall  <= '0;
      t_on    <= '0;
      t_off   <= '0;
    end else if (hs_rise) begin
      hc      <= CW'(1);
      seen    <= 1'b1;
      fell    <= 1'b0;
      de_on   <= 1'b0;
      de_done <= 1'b0;
    end else begin
      if (hc != CAP) hc <= hc + CW'(1);
      if (hs_fall) begin
        t_fall <= hc;
        fell   <= 1'b1;
      end
      if (de_rise) begin
        t_on  <= hc;
        de_on <= 1'b1;
      end
      if (de_fall && de_on && !de_done) begin
        t_off   <= hc;
        de_done <= 1'b1;
      end
    end
  end

  assign bp_len  = hc - t_fall;
  assign act_len = hc - t_on;
  assign fp_len  = hc - t_off;

  // R2: line length window, plus saturation timeout (R12)
  assign e_total = hs_rise && seen &&
                   ((hc < CW'(LINE_MIN_CLK)) || (hc > CW'(LINE_MAX_CLK)));
  assign e_tmo   = seen && !hs_rise && (hc == CW'(LINE_MAX_CLK));
  // R3: sync width and back porch
  assign e_sync  = hs_fall && seen &&
                   ((hc < CW'(HS_MIN_CLK)) || (hc > CW'(HS_MAX_CLK)));
  assign e_bp    = de_rise && seen &&
                   (!fell || de_on || (bp_len < CW'(HBP_MIN_CLK)) || (bp_len > CW'(HBP_MAX_CLK)));
  // R4: active width and front porch
  assign e_act   = de_fall && seen && de_on && !de_done && (act_len != CW'(ACT_CLK));
  assign e_fp    = hs_rise && seen && de_done && (fp_len < CW'(HFP_MIN_CLK));
  assign e_ovl   = hs_rise && seen && de_on && !de_done;

  assign line_err = e_total | e_tmo | e_sync | e_bp | e_act | e_fp | e_ovl;

  a_r12_line_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    hc <= CAP);
  a_r12_line_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hc == CAP) && !hs_rise |=> hc == CAP);
endmodule

// File: rtl/stv_vmeas.sv
module stv_vmeas #(
  parameter int FRAME_MIN_LN = 1058,
  parameter int FRAME_MAX_LN = 2046,
  parameter int VS_MIN_LN    = 1,
  parameter int VS_MAX_LN    = 62,
  parameter int VBP_MIN_LN   = 6,
  parameter int VBP_MAX_LN   = 125,
  parameter int VFP_MIN_LN   = 1,
  parameter int ACT_LN       = 1050
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_rise,
  input  logic vs_fall,
  input  logic line_start,
  input  logic de_rise,
  output logic frame_open,
  output logic frame_err
);
  localparam int CW = $clog2(FRAME_MAX_LN + 2);
  localparam logic [CW-1:0] CAP = CW'(FRAME_MAX_LN + 1);

  logic [CW-1:0] lc, t_vf, first_ln, last_ln, act_cnt;
  logic          started, vfell, de_seen;
  logic [CW-1:0] cur_ln, bp_len, fp_len, span;
  logic          e_vs, e_bp, e_end, e_tmo;

  assign cur_ln = lc - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc       <= '0;
      t_vf     <= '0;
      first_ln <= '0;
      last_ln  <= '0;
      act_cnt  <= '0;
      started  <= 1'b0;
      vfell    <= 1'b0;
      de_seen  <= 1'b0;
    end else if (vs_rise) begin
      lc      <= line_start ? CW'(1) : '0;
      started <= 1'b1;
      vfell   <= 1'b0;
      de_seen <= 1'b0;
      act_cnt <= '0;
    end else begin
      if (line_start && (lc != CAP)) lc <= lc + CW'(1);
      if (vs_fall) begin
        t_vf  <= lc;
        vfell <= 1'b1;
      end
      if (de_rise) begin
        last_ln <= cur_ln;
        if (!de_seen) begin
          first_ln <= cur_ln;
          de_seen  <= 1'b1;
          act_cnt  <= CW'(1);
        end else if (act_cnt != CAP) begin
          act_cnt <= act_cnt + CW'(1);
        end
      end
    end
  end

  assign bp_len = cur_ln - t_vf;
  assign fp_len = cur_ln - last_ln;
  assign span   = last_ln - first_ln + CW'(1);

  // R6: vsync width, back porch; R7 follows from the width window
  assign e_vs  = vs_fall && started &&
                 ((lc < CW'(VS_MIN_LN)) || (lc > CW'(VS_MAX_LN)));
  assign e_bp  = de_rise && started && !de_seen &&
                 (!vfell || (bp_len < CW'(VBP_MIN_LN)) || (bp_len > CW'(VBP_MAX_LN)));
  // R5 and R6: frame length, active count, contiguity, front porch
  assign e_end = vs_rise && started &&
                 ((lc < CW'(FRAME_MIN_LN)) || (lc > CW'(FRAME_MAX_LN)) ||
                  !de_seen || !vfell || (act_cnt != CW'(ACT_LN)) ||
                  (span != act_cnt) || (fp_len < CW'(VFP_MIN_LN)));
  assign e_tmo = started && !vs_rise && line_start && (lc == CW'(FRAME_MAX_LN));

  assign frame_err  = e_vs | e_bp | e_end | e_tmo;
  assign frame_open = started;

  a_r5_frame_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    lc <= CAP);
  a_r5_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open |=> frame_open);
endmodule

// File: rtl/stv_gate.sv
module stv_gate #(
  parameter int PIX_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_open,
  input  logic             err,
  input  logic [PIX_W-1:0] pix_a_in,
  input  logic [PIX_W-1:0] pix_b_in,
  output logic [PIX_W-1:0] pix_a_out,
  output logic [PIX_W-1:0] pix_b_out,
  output logic             timing_valid
);
  logic valid_q, blank_q, dirty_q, clean;

  assign clean = frame_open & ~dirty_q & ~err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blank_q <= 1'b1;
      dirty_q <= 1'b0;
    end else if (frame_start) begin
      valid_q <= clean;
      blank_q <= ~clean;
      dirty_q <= 1'b0;
    end else if (err) begin
      valid_q <= 1'b0;
      dirty_q <= 1'b1;
    end
  end

  assign pix_a_out    = blank_q ? '0 : pix_a_in;
  assign pix_b_out    = blank_q ? '0 : pix_b_in;
  assign timing_valid = valid_q;

  a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    err && !frame_start |=> !timing_valid);
  a_r10_set_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing_valid) |-> $past(frame_start));
  a_r11_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(blank_q));
  a_r1_unblank_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_q) |-> timing_valid);
endmodule

// File: rtl/sync_timing_validator.sv
module sync_timing_validator #(
  parameter int PIX_W        = 18,
  parameter int LINE_MIN_CLK = 762,
  parameter int LINE_MAX_CLK = 1023,
  parameter int HS_MIN_CLK   = 8,
  parameter int HS_MAX_CLK   = 250,
  parameter int HBP_MIN_CLK  = 26,
  parameter int HBP_MAX_CLK  = 300,
  parameter int HFP_MIN_CLK  = 8,
  parameter int ACT_CLK      = 700,
  parameter int FRAME_MIN_LN = 1058,
  parameter int FRAME_MAX_LN = 2046,
  parameter int VS_MIN_LN    = 1,
  parameter int VS_MAX_LN    = 62,
  parameter int VBP_MIN_LN   = 6,
  parameter int VBP_MAX_LN   = 125,
  parameter int VFP_MIN_LN   = 1,
  parameter int ACT_LN       = 1050
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             de_in,
  input  logic [PIX_W-1:0] pix_even_in,
  input  logic [PIX_W-1:0] pix_odd_in,
  output logic [PIX_W-1:0] pix_even_out,
  output logic [PIX_W-1:0] pix_odd_out,
  output logic             timing_valid
);
  import stv_pkg::*;

  logic [SIG_N-1:0] ctl, rise, fall;
  logic             line_err, frame_err, frame_open;

  assign ctl[SIG_HS] = hsync_in;
  assign ctl[SIG_VS] = vsync_in;
  assign ctl[SIG_DE] = de_in;

  stv_edge #(.N(SIG_N)) u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .d (ctl),
    .rise (rise),
    .fall (fall)
  );

  stv_hmeas #(
    .LINE_MIN_CLK (LINE_MIN_CLK),
    .LINE_MAX_CLK (LINE_MAX_CLK),
    .HS_MIN_CLK   (HS_MIN_CLK),
    .HS_MAX_CLK   (HS_MAX_CLK),
    .HBP_MIN_CLK  (HBP_MIN_CLK),
    .HBP_MAX_CLK  (HBP_MAX_CLK),
    .HFP_MIN_CLK  (HFP_MIN_CLK),
    .ACT_CLK      (ACT_CLK)
  ) u_hmeas (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_rise  (rise[SIG_HS]),
    .hs_fall  (fall[SIG_HS]),
    .de_rise  (rise[SIG_DE]),
    .de_fall  (fall[SIG_DE]),
    .line_err (line_err)
  );

  stv_vmeas #(
    .FRAME_MIN_LN (FRAME_MIN_LN),
    .FRAME_MAX_LN (FRAME_MAX_LN),
    .VS_MIN_LN    (VS_MIN_LN),
    .VS_MAX_LN    (VS_MAX_LN),
    .VBP_MIN_LN   (VBP_MIN_LN),
    .VBP_MAX_LN   (VBP_MAX_LN),
    .VFP_MIN_LN   (VFP_MIN_LN),
    .ACT_LN       (ACT_LN)
  ) u_vmeas (
    .clk        (clk),
    .rst_n      (rst_n),
    .vs_rise    (rise[SIG_VS]),
    .vs_fall    (fall[SIG_VS]),
    .line_start (rise[SIG_HS]),
    .de_rise    (rise[SIG_DE]),
    .frame_open (frame_open),
    .frame_err  (frame_err)
  );

  stv_gate #(.PIX_W(PIX_W)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (rise[SIG_VS]),
    .frame_open   (frame_open),
    .err          (line_err | frame_err),
    .pix_a_in     (pix_even_in),
    .pix_b_in     (pix_odd_in),
    .pix_a_out    (pix_even_out),
    .pix_b_out    (pix_odd_out),
    .timing_valid (timing_valid)
  );
endmodule

// File: tb/test_sync_timing_validator.sv
`timescale 1ns/1ps
module test_sync_timing_validator;
  localparam int PW = 18;
  localparam int L_MIN = 14, L_MAX = 24, HS_MIN = 2, HS_MAX = 5;
  localparam int HBP_MIN = 2, HBP_MAX = 5, HFP_MIN = 2, HACT = 6;
  localparam int F_MIN = 9, F_MAX = 14, VS_MIN = 1, VS_MAX = 3;
  localparam int VBP_MIN = 2, VBP_MAX = 4, VFP_MIN = 1, VACT = 4;

  typedef struct {
    int hsw, hbp, hfp;
    int vsw, vbp, vact, vfp;
    int bad_line;
    int b_hsw, b_hbp, b_hact, b_hfp;
    bit neg;
    bit long_line;
  } frm_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [PW-1:0] pe = '0, po = '0;
  logic [PW-1:0] pe_o, po_o;
  logic valid;

  int n_chk = 0, n_fail = 0;
  bit prev_legal = 1'b0;
  string prev_tag = "R1";
  bit chk_pix = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_timing_validator #(
    .PIX_W(PW), .LINE_MIN_CLK(L_MIN), .LINE_MAX_CLK(L_MAX),
    .HS_MIN_CLK(HS_MIN), .HS_MAX_CLK(HS_MAX), .HBP_MIN_CLK(HBP_MIN),
    .HBP_MAX_CLK(HBP_MAX), .HFP_MIN_CLK(HFP_MIN), .ACT_CLK(HACT),
    .FRAME_MIN_LN(F_MIN), .FRAME_MAX_LN(F_MAX), .VS_MIN_LN(VS_MIN),
    .VS_MAX_LN(VS_MAX), .VBP_MIN_LN(VBP_MIN), .VBP_MAX_LN(VBP_MAX),
    .VFP_MIN_LN(VFP_MIN), .ACT_LN(VACT)
  ) i_sync_timing_validator (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .de_in(de),
    .pix_even_in(pe), .pix_odd_in(po), .pix_even_out(pe_o),
    .pix_odd_out(po_o), .timing_valid(valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit line_ok(input int hsw, input int hbp, input int hact, input int hfp);
    int tot = hsw + hbp + hact + hfp;
    return (tot >= L_MIN) && (tot <= L_MAX) && (hsw >= HS_MIN) && (hsw <= HS_MAX) &&
           (hbp >= HBP_MIN) && (hbp <= HBP_MAX) && (hact == HACT) && (hfp >= HFP_MIN);
  endfunction

  function automatic bit frame_ok(input frm_t f);
    int tot = f.vsw + f.vbp + f.vact + f.vfp;
    bit ok = (tot >= F_MIN) && (tot <= F_MAX) && (f.vsw >= VS_MIN) && (f.vsw <= VS_MAX) &&
             (f.vbp >= VBP_MIN) && (f.vbp <= VBP_MAX) && (f.vact == VACT) &&
             (f.vfp >= VFP_MIN) && !f.neg;
    ok = ok && line_ok(f.hsw, f.hbp, HACT, f.hfp);
    if (f.bad_line >= 0) ok = ok && line_ok(f.b_hsw, f.b_hbp, f.b_hact, f.b_hfp);
    return ok;
  endfunction

  function automatic frm_t rand_legal();
    frm_t f;
    int s, lo;
    f.hsw = HS_MIN + int'($urandom % (HS_MAX - HS_MIN + 1));
    f.hbp = HBP_MIN + int'($urandom % (HBP_MAX - HBP_MIN + 1));
    s = f.hsw + f.hbp + HACT;
    lo = (L_MIN - s > HFP_MIN) ? L_MIN - s : HFP_MIN;
    f.hfp = lo + int'($urandom % (L_MAX - s - lo + 1));
    f.vsw = VS_MIN + int'($urandom % (VS_MAX - VS_MIN + 1));
    f.vbp = VBP_MIN + int'($urandom % (VBP_MAX - VBP_MIN + 1));
    f.vact = VACT;
    s = f.vsw + f.vbp + VACT;
    lo = (F_MIN - s > VFP_MIN) ? F_MIN - s : VFP_MIN;
    f.vfp = lo + int'($urandom % (F_MAX - s - lo + 1));
    f.bad_line = -1;
    f.b_hsw = f.hsw; f.b_hbp = f.hbp; f.b_hact = HACT; f.b_hfp = f.hfp;
    f.neg = 1'b0;
    f.long_line = 1'b0;
    return f;
  endfunction

  // kinds: 0 legal, 1 wide hsync R3, 2 short hbp R3, 3 long active R4,
  // 4 short hfp R4, 5 missing hsync R12, 6 short line R2, 7 wide vsync R6,
  // 8 short vbp R6, 9 few active lines R5, 10 no vfp R6, 11 long frame R5
  function automatic frm_t mutate(input frm_t f, input int kind, output string tag);
    tag = "R10";
    if (kind >= 1 && kind <= 6) f.bad_line = f.vsw + f.vbp;
    case (kind)
      1: begin f.b_hsw = HS_MAX + 2; tag = "R3"; end
      2: begin f.b_hbp = HBP_MIN - 1; tag = "R3"; end
      3: begin f.b_hact = HACT + 1; tag = "R4"; end
      4: begin f.b_hfp = HFP_MIN - 1; tag = "R4"; end
      5: begin f.b_hfp = 30; f.long_line = 1'b1; tag = "R12"; end
      6: begin f.b_hsw = HS_MIN; f.b_hbp = HBP_MIN; f.b_hfp = HFP_MIN; tag = "R2"; end
      7: begin f.vsw = VS_MAX + 2; tag = "R6"; end
      8: begin f.vbp = VBP_MIN - 1; tag = "R6"; end
      9: begin f.vact = VACT - 1; tag = "R5"; end
      10: begin f.vfp = 0; tag = "R6"; end
      11: begin f.vfp = F_MAX + 1 - (f.vsw + f.vbp + f.vact); tag = "R5"; end
      default: ;
    endcase
    return f;
  endfunction

  task automatic cyc(input logic h, input logic v, input logic d);
    hs = h; vs = v; de = d;
    pe = PW'($urandom) | PW'(1);
    po = PW'($urandom) | PW'(1);
    #1;
    if (d && chk_pix) begin
      if (prev_legal) check("R11 pixels pass", {pe_o, po_o}, {pe, po});
      else            check("R8 pixels black", {pe_o, po_o}, '0);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(input frm_t f, input bit do_check, input string tag);
    int nl = f.vsw + f.vbp + f.vact + f.vfp;
    int a0 = f.vsw + f.vbp;
    bit legal = frame_ok(f);
    chk_pix = do_check;
    for (int l = 0; l < nl; l++) begin
      bit act = (l >= a0) && (l < a0 + f.vact);
      bit vl = (l < f.vsw) ^ f.neg;
      bit bad = (l == f.bad_line);
      int hsw = bad ? f.b_hsw : f.hsw;
      int hbp = bad ? f.b_hbp : f.hbp;
      int ha = bad ? f.b_hact : HACT;
      int hfp = bad ? f.b_hfp : f.hfp;
      int tot = hsw + hbp + ha + hfp;
      for (int c = 0; c < tot; c++) begin
        cyc(c < hsw, vl, act && (c >= hsw + hbp) && (c < hsw + hbp + ha));
        if (l == 0 && c == 1 && do_check)
          check({prev_tag, " valid at frame boundary"}, 64'(valid), 64'(prev_legal));
      end
      if (bad && f.long_line)
        check("R12 timeout before hsync returns", 64'(valid), 64'd0);
      if (f.bad_line >= 0 && l == f.bad_line + 1 && do_check)
        check("R9 valid drops mid-frame", 64'(valid), 64'd0);
    end
    prev_legal = legal;
    prev_tag = legal ? "R10" : tag;
  endtask

  initial begin
    frm_t f;
    string tag;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      hs = 1'b0; vs = 1'b0; de = 1'b1;
      pe = PW'($urandom) | PW'(1); po = PW'($urandom) | PW'(1);
      #1;
      check("R1 reset valid", 64'(valid), 64'd0);
      check("R1 reset pixels black", {pe_o, po_o}, '0);
      @(posedge clk); @(negedge clk);
    end
    de = 1'b0;
    // first frame: blanked, valid set at its end (R1)
    run_frame(rand_legal(), 1'b1, "R1");
    for (int i = 0; i < 3; i++) run_frame(rand_legal(), 1'b1, "R10");
    // directed violations, each followed by recovery frames
    for (int k = 1; k <= 11; k++) begin
      f = mutate(rand_legal(), k, tag);
      run_frame(f, 1'b1, tag);
      run_frame(rand_legal(), 1'b1, "R10");
      run_frame(rand_legal(), 1'b1, "R10");
    end
    // inverted vsync (R7): framing is broken, checks resume two frames later
    f = rand_legal(); f.neg = 1'b1;
    run_frame(f, 1'b0, "R7");
    run_frame(f, 1'b0, "R7");
    run_frame(rand_legal(), 1'b0, "R7");
    prev_legal = 1'b0; prev_tag = "R7";
    run_frame(rand_legal(), 1'b1, "R10");
    run_frame(rand_legal(), 1'b1, "R10");
    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      int k = ($urandom % 10 < 3) ? 1 + int'($urandom % 11) : 0;
      f = mutate(rand_legal(), k, tag);
      run_frame(f, 1'b1, tag);
    end
    run_frame(rand_legal(), 1'b1, "R10");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule